// File: doc/BRIEF.md
# Programmable Counter Array

This block pairs one shared 16-bit up-counter with a set of independent channels. Each channel watches that counter and, depending on its mode, latches the count when its capture input changes, raises a flag when the count reaches a stored value, toggles its output on such a match, produces a square wave whose half period is a number of counter steps, or drives a pulse-width modulated output. The counter advances on a selectable source: every clock, every (divisor+1) clocks, or each rising edge of an external tick input.

Software reaches the block through a flat word-wide register port: writes are single-cycle strobes, and reads are combinational from the address. Flags for counter wrap and for channel events are sticky and are cleared by writing ones. A kill input, which is not synchronised, drives every PWM channel to its idle level at once.

Register map (word addresses): 0 control (bit 0 run, bits 2:1 clock source with 0 = every clock, 1 = prescaled, 2 = external tick edges, 3 = halted, bits 15:8 divisor); 1 counter value; 2 flags (bit 15 counter wrap, bit i channel i). Channel i uses base 4*(i+1): base+0 setup, base+1 compare value, base+2 captured value. The setup word holds mode in bits 2:0 (0 off, 1 capture, 2 timer, 3 toggle, 4 square wave, 5 PWM), rising-edge enable in bit 3, falling-edge enable in bit 4, resolution code in bits 7:5, centred PWM in bit 8 and output inversion in bit 9.

Top module: `pca_core`

## Requirements
- R1: After reset the counter reads 0, all flags read 0 and every channel output is low.
- R2: While run is 1 the counter increments once per tick. Source 0 ticks every clock, source 1 every divisor+1 clocks, source 2 on each rising edge of ext_tick, and source 3 never. With run at 0 the counter holds.
- R3: A tick taken with the counter at 0xFFFF wraps it to 0 and sets flag bit 15.
- R4: Writing the flags register clears each flag whose written bit is 1. Flags written with 0 keep their value.
- R5: In capture mode the counter value is stored in the captured register and the channel flag is set on each capture-input edge enabled by setup bits 3 (rising) and 4 (falling). Edges that are not enabled change neither.
- R6: In timer mode the channel flag is set when the counter steps onto the compare value, and the output does not move.
- R7: In toggle mode a step onto the compare value inverts the channel output and sets the channel flag.
- R8: In square-wave mode the output inverts each time the counter low byte steps onto compare bits 7:0. Those bits then grow by compare bits 15:8, so the half period is that many counter steps.
- R9: In PWM mode resolution code 0, 1, 2, 3 or 4 selects 8, 9, 10, 11 or 16 bits. In edge-aligned form the output is active while the counter's low n bits are below the compare value's low n bits.
- R10: With setup bit 8 set, the PWM output is active for the same number of steps per period (even compare values), centred on the wrap of the low n bits.
- R11: Setup bit 9 inverts the channel output in every mode.
- R12: While kill is 1 every PWM channel output shows its idle level (setup bit 9), at once and with no clock. Other modes are unaffected.
- R13: In PWM mode a new compare value takes effect only when the counter's low n bits wrap. In other modes it takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| ext_tick | input | 1 | External counter tick, asynchronous |
| cap_in | input | N_CH (6) | Per-channel capture inputs, asynchronous |
| kill | input | 1 | Forces PWM outputs idle |
| ch_out | output | N_CH (6) | Channel outputs |

## Verification
The PWM checks sample the output against the counter at points chosen to separate the resolutions. A mask one size off, for example comparing only the low byte at 16-bit resolution, flips the output at counts such as 0x8FFF. The double-buffer test writes a new compare value in the middle of a period and looks inside that same period. A design that loaded the value at once would turn the output on there. The centred test checks the points just inside and outside the symmetric pulse, so an off-by-one in the folded compare shows at 0x1F/0x20 or 0xDF/0xE0. Capture checks that a disabled edge leaves both the stored value and the flag alone, and the kill test checks the idle level with inversion both on and off.

// File: rtl/pca_pkg.sv
// Shared types, constants and the resolution-mask function of the
// counter array. Assumes a 16-bit data path and an 8-bit frequency byte.
package pca_pkg;

    localparam int CNT_W    = 16;
    localparam int FREQ_W   = 8;
    localparam int OVF_BIT  = 15;

    // register word addresses
    localparam int REG_CTRL  = 0;
    localparam int REG_COUNT = 1;
    localparam int REG_FLAGS = 2;
    localparam int CH_STRIDE = 4;
    localparam int CH_CFG    = 0;
    localparam int CH_CMP    = 1;
    localparam int CH_CAP    = 2;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_CAPTURE = 3'd1,
        MODE_TIMER   = 3'd2,
        MODE_TOGGLE  = 3'd3,
        MODE_FREQ    = 3'd4,
        MODE_PWM     = 3'd5
    } ch_mode_t;

    typedef struct packed {
        logic [5:0] spare;
        logic       invert;
        logic       centre;
        logic [2:0] res;
        logic       fall;
        logic       rise;
        ch_mode_t   mode;
    } ch_cfg_t;

    // low-bit mask for a PWM resolution code
    function automatic logic [CNT_W-1:0] res_mask(input logic [2:0] code);
        int bits;
        case (code)
            3'd0:    bits = 8;
            3'd1:    bits = 9;
            3'd2:    bits = 10;
            3'd3:    bits = 11;
            default: bits = CNT_W;
        endcase
        res_mask = (bits >= CNT_W) ? '1 : CNT_W'((32'd1 << bits) - 32'd1);
    endfunction

endpackage

// File: rtl/pca_sync.sv
// Two-stage synchroniser for asynchronous inputs.
// Assumes each bit is independent; adds two cycles of latency.
module pca_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // two flops in series per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/pca_timebase.sv
// Shared counter with clock-source selection and prescaler.
// adv marks a cycle whose edge increments the counter; step marks the
// cycle after, in which the new count is visible. A load has priority.
module pca_timebase
    import pca_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       src,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    input  logic             ext_s,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             adv,
    output logic             step
);
    logic             ext_q;
    logic [DIV_W-1:0] pre_q;
    logic             pre_hit;
    logic             tick;

    assign pre_hit = (pre_q == div);

    // pick the tick source
    always_comb begin
        case (src)
            2'd0:    tick = 1'b1;
            2'd1:    tick = pre_hit;
            2'd2:    tick = ext_s & ~ext_q;
            default: tick = 1'b0;
        endcase
    end

    assign adv = run & tick & ~load;

    // prescaler: counts 0..div, restarts on control writes
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || src != 2'd1) pre_q <= '0;
        else if (pre_hit)                               pre_q <= '0;
        else                                            pre_q <= pre_q + 1'b1;
    end

    // edge memory of the synchronised external tick
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_s;
    end

    // counter and step marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            step <= 1'b0;
        end else begin
            step <= adv;
            if (load)     cnt <= load_val;
            else if (adv) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pca_channel.sv
// One capture/compare channel. Holds its setup word, a shadow and an
// active compare value, the captured count and a toggle state.
// Assumes cap_s is already synchronised; kill acts combinationally.
module pca_channel
    import pca_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             adv,
    input  logic             step,
    input  logic             cap_s,
    input  logic             kill,
    output ch_cfg_t          cfg_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             event_o,
    output logic             out_o
);
    ch_cfg_t          cfg_q;
    logic [CNT_W-1:0] sh_q, act_q, cap_q;
    logic [CNT_W-1:0] mask, v, c, fold;
    logic             cap_prev, tog_q;
    logic             period_end, hit, hit_lo, cap_ev, pwm_on, wave;

    assign mask       = res_mask(cfg_q.res);
    assign v          = cnt & mask;
    assign c          = act_q & mask;
    assign period_end = adv && (v == mask);
    assign hit        = step && (cnt == act_q);
    assign hit_lo     = step && (cnt[FREQ_W-1:0] == act_q[FREQ_W-1:0]);
    assign cap_ev     = (cfg_q.mode == MODE_CAPTURE) &&
                        ((cfg_q.rise && cap_s && !cap_prev) ||
                         (cfg_q.fall && !cap_s && cap_prev));
    assign fold       = (v > (mask >> 1)) ? (mask - v) : v;
    assign pwm_on     = cfg_q.centre ? ({fold, 1'b0} < {1'b0, c}) : (v < c);

    // setup word
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= ch_cfg_t'(wdata);
    end

    // shadow/active compare values, PWM reload and frequency advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
        end else if (cmp_wr) begin
            sh_q <= wdata;
            if (cfg_q.mode != MODE_PWM) act_q <= wdata;
        end else if (cfg_q.mode == MODE_PWM && period_end) begin
            act_q <= sh_q;
        end else if (cfg_q.mode == MODE_FREQ && hit_lo) begin
            act_q[FREQ_W-1:0] <= act_q[FREQ_W-1:0] + act_q[2*FREQ_W-1:FREQ_W];
        end
    end

    // capture edge memory and captured count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_prev <= 1'b0;
            cap_q    <= '0;
        end else begin
            cap_prev <= cap_s;
            if (cap_ev) cap_q <= cnt;
        end
    end

    // toggle state for toggle and square-wave modes
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr)                          tog_q <= 1'b0;
        else if (cfg_q.mode == MODE_TOGGLE && hit)     tog_q <= ~tog_q;
        else if (cfg_q.mode == MODE_FREQ && hit_lo)    tog_q <= ~tog_q;
    end

    // waveform selection per mode, kill applied to PWM only
    always_comb begin
        case (cfg_q.mode)
            MODE_PWM:                wave = pwm_on & ~kill;
            MODE_TOGGLE, MODE_FREQ:  wave = tog_q;
            default:                 wave = 1'b0;
        endcase
    end

    assign out_o   = wave ^ cfg_q.invert;
    assign event_o = cap_ev ||
                     ((cfg_q.mode == MODE_TIMER || cfg_q.mode == MODE_TOGGLE) && hit);
    assign cfg_o   = cfg_q;
    assign cmp_o   = act_q;
    assign cap_o   = cap_q;
endmodule

// File: rtl/pca_core.sv
// Top of the counter array: register port, control and flag registers,
// the shared timebase and N_CH channels. Assumes N_CH < OVF_BIT and
// DIV_W <= 8 so the control and flag words hold every field.
module pca_core
    import pca_pkg::*;
#(
    parameter  int N_CH   = 6,
    parameter  int DIV_W  = 8,
    localparam int ADDR_W = $clog2(CH_STRIDE * (N_CH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              ext_tick,
    input  logic [N_CH-1:0]   cap_in,
    input  logic              kill,
    output logic [N_CH-1:0]   ch_out
);
    logic             run_q;
    logic [1:0]       src_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] flags_q, set_vec;
    logic             ctrl_wr, cnt_wr, flag_wr;
    logic [CNT_W-1:0] cnt;
    logic             adv, step, ext_s, ovf_set;
    logic [N_CH-1:0]  cap_s, ev, pwm_mask, inv_mask;
    ch_cfg_t          cfg_w [N_CH];
    logic [CNT_W-1:0] cmp_w [N_CH];
    logic [CNT_W-1:0] cap_w [N_CH];

    assign ctrl_wr = wr_en && addr == ADDR_W'(REG_CTRL);
    assign cnt_wr  = wr_en && addr == ADDR_W'(REG_COUNT);
    assign flag_wr = wr_en && addr == ADDR_W'(REG_FLAGS);
    assign ovf_set = adv && (&cnt);

    pca_sync #(.W(N_CH + 1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ext_tick, cap_in}), .q({ext_s, cap_s})
    );

    pca_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_q), .src(src_q), .div(div_q),
        .restart(ctrl_wr), .ext_s(ext_s), .load(cnt_wr), .load_val(wdata),
        .cnt(cnt), .adv(adv), .step(step)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CH_STRIDE * (i + 1) + CH_CFG);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CH_STRIDE * (i + 1) + CH_CMP);
        pca_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr(wr_en && addr == CFG_A), .cmp_wr(wr_en && addr == CMP_A),
            .wdata(wdata), .cnt(cnt), .adv(adv), .step(step),
            .cap_s(cap_s[i]), .kill(kill),
            .cfg_o(cfg_w[i]), .cmp_o(cmp_w[i]), .cap_o(cap_w[i]),
            .event_o(ev[i]), .out_o(ch_out[i])
        );
        assign pwm_mask[i] = (cfg_w[i].mode == MODE_PWM);
        assign inv_mask[i] = cfg_w[i].invert;
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            src_q <= 2'd0;
            div_q <= '0;
        end else if (ctrl_wr) begin
            run_q <= wdata[0];
            src_q <= wdata[2:1];
            div_q <= wdata[8 +: DIV_W];
        end
    end

    // flag set sources
    always_comb begin
        set_vec             = '0;
        set_vec[OVF_BIT]    = ovf_set;
        set_vec[N_CH-1:0]   = ev;
    end

    // sticky flags, write one to clear, a new set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(flag_wr ? wdata : '0)) | set_vec;
    end

    // combinational read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rdata[0]          = run_q;
            rdata[2:1]        = src_q;
            rdata[8 +: DIV_W] = div_q;
        end else if (addr == ADDR_W'(REG_COUNT)) begin
            rdata = cnt;
        end else if (addr == ADDR_W'(REG_FLAGS)) begin
            rdata = flags_q;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (addr == ADDR_W'(CH_STRIDE * (i + 1) + CH_CFG)) rdata = cfg_w[i];
            if (addr == ADDR_W'(CH_STRIDE * (i + 1) + CH_CMP)) rdata = cmp_w[i];
            if (addr == ADDR_W'(CH_STRIDE * (i + 1) + CH_CAP)) rdata = cap_w[i];
        end
    end
endmodule

// File: rtl/pca_core_chk.sv
// Property checker for pca_core, attached by bind below.
// Observes the counter, flags, kill path and channel events.
module pca_core_chk #(
    parameter int N_CH = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            kill,
    input logic [N_CH-1:0] ch_out,
    input logic [15:0]     flags,
    input logic            adv,
    input logic            cnt_load,
    input logic [15:0]     cnt,
    input logic [N_CH-1:0] pwm_mask,
    input logic [N_CH-1:0] inv_mask,
    input logic [N_CH-1:0] ev,
    input logic            flag_wr,
    input logic [15:0]     wdata
);
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cnt == $past(cnt) + 16'd1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_load) |=> $stable(cnt));

    a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == 16'hFFFF) |=> (flags[15] && cnt == 16'h0000));

    a_r4_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[15]) |-> $past(flag_wr && wdata[15]));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        a_r12_kill_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (kill && pwm_mask[i]) |-> (ch_out[i] == inv_mask[i]));

        a_r5_event_flag: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flags[i]);
    end
endmodule

bind pca_core pca_core_chk #(.N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .kill(kill), .ch_out(ch_out), .flags(flags_q),
    .adv(adv), .cnt_load(cnt_wr), .cnt(cnt), .pwm_mask(pwm_mask),
    .inv_mask(inv_mask), .ev(ev), .flag_wr(flag_wr), .wdata(wdata)
);

// File: tb/pca_core_test.sv
// Directed bench for pca_core: one task per scenario, each self-checking.
module pca_core_test;
    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [4:0]     addr = '0;
    logic [15:0]    wdata = '0;
    logic [15:0]    rdata;
    logic           ext_tick = 1'b0;
    logic [NCH-1:0] cap_in = '0;
    logic           kill = 1'b0;
    logic [NCH-1:0] ch_out;
    int             tests = 0;
    int             fails = 0;

    pca_core #(.N_CH(NCH), .DIV_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_tick(ext_tick), .cap_in(cap_in), .kill(kill),
        .ch_out(ch_out)
    );

    always #5 clk = ~clk;

    function automatic logic [4:0] cha(input int ch, input int sub);
        return 5'(4 * (ch + 1) + sub);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic win(input int m, output int diff);
        logic [15:0] a, b;
        rd(5'd1, a);
        repeat (m) @(negedge clk);
        #1 b = rdata;
        diff = int'(16'(b - a));
    endtask

    task automatic duty(input int ch, input int n, output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            #1 ones += int'(ch_out[ch]);
        end
    endtask

    task automatic wait_low(input logic [7:0] val);
        do begin
            @(negedge clk);
            addr = 5'd1;
            #1;
        end while (rdata[7:0] != val);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(5'd1, d); check(d == 0, "R1 counter", d, 0);
        rd(5'd2, d); check(d == 0, "R1 flags", d, 0);
        check(ch_out == '0, "R1 outputs", ch_out, 0);
    endtask

    task automatic t_timebase;
        int diff;
        wr(5'd1, 16'h0000);
        wr(5'd0, 16'h0001);
        win(20, diff); check(diff == 20, "R2 every clock", diff, 20);
        wr(5'd0, 16'h0303);
        repeat (8) @(negedge clk);
        win(40, diff); check(diff == 10, "R2 prescaled", diff, 10);
        wr(5'd0, 16'h0005);
        begin
            logic [15:0] a, b;
            rd(5'd1, a);
            for (int k = 0; k < 5; k++) begin
                ext_tick = 1'b1; repeat (3) @(negedge clk);
                ext_tick = 1'b0; repeat (3) @(negedge clk);
            end
            repeat (6) @(negedge clk);
            #1 b = rdata;
            check(16'(b - a) == 5, "R2 external ticks", 16'(b - a), 5);
        end
        wr(5'd0, 16'h0007);
        win(20, diff); check(diff == 0, "R2 halted source", diff, 0);
        wr(5'd0, 16'h0000);
        win(20, diff); check(diff == 0, "R2 run off", diff, 0);
    endtask

    task automatic t_wrap;
        logic [15:0] d;
        wr(5'd2, 16'hFFFF);
        wr(5'd1, 16'hFFF0);
        wr(5'd0, 16'h0001);
        repeat (30) @(negedge clk);
        wr(5'd0, 16'h0000);
        rd(5'd2, d); check(d[15] == 1'b1, "R3 wrap flag", d, 16'h8000);
        wr(5'd2, 16'h0000);
        rd(5'd2, d); check(d[15] == 1'b1, "R4 zero write keeps", d, 16'h8000);
        wr(5'd2, 16'h8000);
        rd(5'd2, d); check(d[15] == 1'b0, "R4 one write clears", d, 0);
    endtask

    task automatic t_capture;
        logic [15:0] d;
        wr(cha(0, 0), 16'h0009);
        wr(5'd2, 16'hFFFF);
        wr(5'd1, 16'h1234);
        cap_in[0] = 1'b1; repeat (6) @(negedge clk);
        rd(cha(0, 2), d); check(d == 16'h1234, "R5 rising capture", d, 16'h1234);
        rd(5'd2, d); check(d[0] == 1'b1, "R5 capture flag", d, 1);
        wr(5'd2, 16'hFFFF);
        wr(5'd1, 16'h2222);
        cap_in[0] = 1'b0; repeat (6) @(negedge clk);
        rd(cha(0, 2), d); check(d == 16'h1234, "R5 disabled edge value", d, 16'h1234);
        rd(5'd2, d); check(d[0] == 1'b0, "R5 disabled edge flag", d, 0);
        wr(cha(0, 0), 16'h0019);
        wr(5'd1, 16'h3333);
        cap_in[0] = 1'b1; repeat (6) @(negedge clk);
        rd(cha(0, 2), d); check(d == 16'h3333, "R5 both edges rise", d, 16'h3333);
        wr(5'd1, 16'h4444);
        cap_in[0] = 1'b0; repeat (6) @(negedge clk);
        rd(cha(0, 2), d); check(d == 16'h4444, "R5 both edges fall", d, 16'h4444);
    endtask

    task automatic t_timer;
        logic [15:0] d;
        wr(cha(1, 0), 16'h0002);
        wr(cha(1, 1), 16'h0105);
        wr(5'd1, 16'h0100);
        wr(5'd2, 16'hFFFF);
        wr(5'd0, 16'h0001);
        repeat (20) @(negedge clk);
        wr(5'd0, 16'h0000);
        rd(5'd2, d); check(d[1] == 1'b1, "R6 timer flag", d, 2);
        check(ch_out[1] == 1'b0, "R6 output still", ch_out[1], 0);
    endtask

    task automatic t_toggle;
        logic [15:0] d;
        wr(cha(2, 0), 16'h0003);
        wr(cha(2, 1), 16'h0205);
        wr(5'd1, 16'h0200);
        wr(5'd2, 16'hFFFF);
        wr(5'd0, 16'h0001);
        repeat (20) @(negedge clk);
        wr(5'd0, 16'h0000);
        check(ch_out[2] == 1'b1, "R7 first toggle", ch_out[2], 1);
        rd(5'd2, d); check(d[2] == 1'b1, "R7 toggle flag", d, 4);
        wr(5'd1, 16'h0200);
        wr(5'd0, 16'h0001);
        repeat (20) @(negedge clk);
        wr(5'd0, 16'h0000);
        check(ch_out[2] == 1'b0, "R7 second toggle", ch_out[2], 0);
    endtask

    task automatic t_freq;
        int stamp [4];
        int n = 0;
        int cyc = 0;
        logic last;
        wr(cha(3, 0), 16'h0004);
        wr(cha(3, 1), 16'h0A20);
        wr(5'd1, 16'h0000);
        wr(5'd0, 16'h0001);
        last = ch_out[3];
        while (n < 4 && cyc < 400) begin
            @(negedge clk); #1 cyc++;
            if (ch_out[3] != last) begin
                stamp[n] = cyc; n++; last = ch_out[3];
            end
        end
        wr(5'd0, 16'h0000);
        check(n == 4, "R8 toggles seen", n, 4);
        for (int k = 1; k < 4; k++)
            check(stamp[k] - stamp[k-1] == 10, "R8 half period",
                  stamp[k] - stamp[k-1], 10);
    endtask

    task automatic pwm_point(input logic [15:0] c, input bit exp, input string req);
        wr(5'd1, c);
        check(ch_out[4] == exp, req, ch_out[4], exp);
    endtask

    task automatic t_pwm_edge;
        int ones;
        wr(cha(4, 0), 16'h0000);
        wr(cha(4, 1), 16'h0040);
        wr(cha(4, 0), 16'h0005);
        wr(5'd1, 16'h0000);
        wr(5'd0, 16'h0001);
        duty(4, 256, ones); check(ones == 64, "R9 8-bit duty", ones, 64);
        wr(cha(4, 1), 16'h0123);
        wr(cha(4, 0), 16'h0025);
        repeat (600) @(negedge clk);
        duty(4, 512, ones); check(ones == 16'h123, "R9 9-bit duty", ones, 16'h123);
        wr(5'd0, 16'h0000);
        wr(cha(4, 0), 16'h0000);
        wr(cha(4, 1), 16'h0300);
        wr(cha(4, 0), 16'h0045);
        pwm_point(16'h06FF, 1'b1, "R9 10-bit below");
        pwm_point(16'h0700, 1'b0, "R9 10-bit at");
        wr(cha(4, 0), 16'h0065);
        pwm_point(16'h0AFF, 1'b1, "R9 11-bit masked");
        pwm_point(16'h0300, 1'b0, "R9 11-bit at");
        wr(cha(4, 0), 16'h0000);
        wr(cha(4, 1), 16'h9000);
        wr(cha(4, 0), 16'h0085);
        pwm_point(16'h8FFF, 1'b1, "R9 16-bit below");
        pwm_point(16'h9000, 1'b0, "R9 16-bit at");
    endtask

    task automatic t_pwm_centre;
        int ones;
        wr(cha(4, 0), 16'h0000);
        wr(cha(4, 1), 16'h0040);
        wr(cha(4, 0), 16'h0105);
        pwm_point(16'h0000, 1'b1, "R10 wrap start");
        pwm_point(16'h001F, 1'b1, "R10 inner low");
        pwm_point(16'h0020, 1'b0, "R10 outer low");
        pwm_point(16'h0080, 1'b0, "R10 middle");
        pwm_point(16'h00DF, 1'b0, "R10 outer high");
        pwm_point(16'h00E0, 1'b1, "R10 inner high");
        pwm_point(16'h00FF, 1'b1, "R10 wrap end");
        wr(5'd0, 16'h0001);
        duty(4, 256, ones); check(ones == 64, "R10 centred duty", ones, 64);
        wr(5'd0, 16'h0000);
    endtask

    task automatic t_polarity;
        wr(cha(4, 0), 16'h0205);
        pwm_point(16'h0010, 1'b0, "R11 inverted active");
        pwm_point(16'h0080, 1'b1, "R11 inverted idle");
    endtask

    task automatic t_kill;
        wr(cha(4, 0), 16'h0005);
        wr(cha(1, 0), 16'h0202);
        wr(5'd1, 16'h0010);
        check(ch_out[4] == 1'b1, "R12 before kill", ch_out[4], 1);
        kill = 1'b1; #1;
        check(ch_out[4] == 1'b0, "R12 kill idle low", ch_out[4], 0);
        check(ch_out[1] == 1'b1, "R12 non-PWM kept", ch_out[1], 1);
        wr(cha(4, 0), 16'h0205);
        check(ch_out[4] == 1'b1, "R12 kill idle inverted", ch_out[4], 1);
        kill = 1'b0; #1;
        check(ch_out[4] == 1'b0, "R12 release", ch_out[4], 0);
    endtask

    task automatic t_dbuf;
        wr(cha(5, 0), 16'h0000);
        wr(cha(5, 1), 16'h0040);
        wr(cha(5, 0), 16'h0005);
        wr(5'd1, 16'h0000);
        wr(5'd0, 16'h0001);
        wait_low(8'h50);
        wr(cha(5, 1), 16'h00C0);
        check(ch_out[5] == 1'b0, "R13 old value in period", ch_out[5], 0);
        wait_low(8'h10);
        wait_low(8'h60);
        check(ch_out[5] == 1'b1, "R13 new value after wrap", ch_out[5], 1);
        wr(5'd0, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_timebase;
        t_wrap;
        t_capture;
        t_timer;
        t_toggle;
        t_freq;
        t_pwm_edge;
        t_pwm_centre;
        t_polarity;
        t_kill;
        t_dbuf;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule